// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block holds a small set of finished page translations so that a virtual address can be turned into a physical address without walking the page tables. It is fully associative. Each entry is tagged by its virtual page number and an address-space identifier. The page offset bits never take part in matching.

A lookup is purely combinational. In the same cycle it returns either a hit with the physical address or a miss. On a miss the surrounding logic starts a table walk and writes the result back through the fill port. When every slot is occupied, a fill replaces the least recently used entry.

Three invalidate commands remove stale translations without discarding everything:
- a full flush;
- removal of every entry whose page lies in an inclusive page range;
- removal of every entry that carries a given identifier, for use when that identifier is handed to a new address space.

Top module: `asid_tlb`

## Requirements
- R1: A lookup hits only when a valid entry matches both the page number (upper 20 bits of the 32-bit virtual address) and the 8-bit identifier. The 12 offset bits play no part in the match.
- R2: On a hit the physical address is the entry's physical page number in bits 31:12 and the lookup's own offset in bits 11:0. It appears in the same cycle as the lookup.
- R3: A valid lookup that matches no entry raises the miss output. Hit and miss are never high together, and both are low when no lookup is presented.
- R4: A fill with no matching entry goes to the lowest-numbered invalid slot. Starting from empty, 16 distinct fills are therefore all held at once.
- R5: When all 16 slots are valid, a new fill replaces the entry that was least recently hit or filled. A hit or a fill makes its entry the most recent one on the next clock edge.
- R6: A fill whose identifier and page number equal those of a valid entry overwrites that entry in place, and no second copy is made.
- R7: The full flush command (inv_op_i = 1) clears every entry on the next clock edge.
- R8: The identifier command (inv_op_i = 2) clears every entry whose identifier equals inv_asid_i and leaves all other entries.
- R9: The range command (inv_op_i = 3) clears every entry whose page number lies in the inclusive range inv_vpn_lo_i to inv_vpn_hi_i, whatever its identifier. Entries outside the range are kept.
- R10: An invalidation in the same cycle as a fill takes priority. The filled entry is dropped if the command covers it and kept if the command does not.
- R11: After reset no entry is valid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | A lookup is presented |
| lk_asid_i | input | 8 | Identifier of the lookup |
| lk_vaddr_i | input | 32 | Virtual address to translate |
| lk_hit_o | output | 1 | Translation found |
| lk_miss_o | output | 1 | No translation; a walk is needed |
| lk_paddr_o | output | 32 | Physical address, valid with hit |
| fill_valid_i | input | 1 | Write a translation |
| fill_asid_i | input | 8 | Identifier of the new entry |
| fill_vpn_i | input | 20 | Virtual page number of the new entry |
| fill_ppn_i | input | 20 | Physical page number of the new entry |
| inv_op_i | input | 2 | 0 none, 1 flush all, 2 by identifier, 3 by page range |
| inv_asid_i | input | 8 | Identifier for command 2 |
| inv_vpn_lo_i | input | 20 | Lowest page of the range, inclusive |
| inv_vpn_hi_i | input | 20 | Highest page of the range, inclusive |

## Verification
The following are checked by assertions on every cycle:
- hit and miss are exclusive and follow the lookup strobe;
- the offset passes through unchanged on a hit;
- a flush, identifier or range command leaves no entry that a lookup in the next cycle could hit;
- an entry filled without a competing command can be looked up in the next cycle.

Replacement order, the choice of the lowest free slot, in-place overwrite and the survival of entries outside an invalidation all depend on the history of many cycles. Only the directed scenarios can show these, by filling the buffer and probing each page afterwards.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  typedef enum logic [1:0] {
    INV_NONE  = 2'd0,
    INV_ALL   = 2'd1,
    INV_ASID  = 2'd2,
    INV_RANGE = 2'd3
  } inv_op_e;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic [N-1:0]             valid_i,
  input  logic [N-1:0][VPN_W-1:0]  vpn_i,
  input  logic [N-1:0][ASID_W-1:0] asid_i,
  input  logic [VPN_W-1:0]         key_vpn_i,
  input  logic [ASID_W-1:0]        key_asid_i,
  output logic [N-1:0]             match_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (vpn_i[g] == key_vpn_i) && (asid_i[g] == key_asid_i);
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          touch_i,
  input  logic [IW-1:0] touch_idx_i,
  output logic [IW-1:0] lru_idx_o
);
  // age 0 = most recent, N-1 = least recent; ages stay a permutation
  logic [N-1:0][IW-1:0] age_q;
  logic [IW-1:0]        ref_age;

  assign ref_age = age_q[touch_idx_i];

  for (genvar g = 0; g < N; g++) begin : g_age
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        age_q[g] <= IW'(g);
      end else if (touch_i) begin
        if (touch_idx_i == IW'(g))   age_q[g] <= '0;
        else if (age_q[g] < ref_age) age_q[g] <= age_q[g] + 1'b1;
      end
    end
  end

  always_comb begin
    lru_idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (age_q[i] == IW'(N - 1)) lru_idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/tlb_kill.sv
module tlb_kill #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8
) (
  input  asid_tlb_pkg::inv_op_e    op_i,
  input  logic [ASID_W-1:0]        asid_i,
  input  logic [VPN_W-1:0]         lo_i,
  input  logic [VPN_W-1:0]         hi_i,
  input  logic [N-1:0][VPN_W-1:0]  ent_vpn_i,
  input  logic [N-1:0][ASID_W-1:0] ent_asid_i,
  output logic [N-1:0]             kill_o
);
  import asid_tlb_pkg::*;
  for (genvar g = 0; g < N; g++) begin : g_kill
    always_comb begin
      unique case (op_i)
        INV_ALL:   kill_o[g] = 1'b1;
        INV_ASID:  kill_o[g] = (ent_asid_i[g] == asid_i);
        INV_RANGE: kill_o[g] = (ent_vpn_i[g] >= lo_i) && (ent_vpn_i[g] <= hi_i);
        default:   kill_o[g] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int N      = 16,
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int OFF_W  = 12,
  localparam int VA_W  = VPN_W + OFF_W,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic [VA_W-1:0]   lk_vaddr_i,
  output logic              lk_hit_o,
  output logic              lk_miss_o,
  output logic [PA_W-1:0]   lk_paddr_o,
  input  logic              fill_valid_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic [1:0]        inv_op_i,
  input  logic [ASID_W-1:0] inv_asid_i,
  input  logic [VPN_W-1:0]  inv_vpn_lo_i,
  input  logic [VPN_W-1:0]  inv_vpn_hi_i
);
  import asid_tlb_pkg::*;
  localparam int IW = $clog2(N);

  logic [N-1:0]             valid_q, valid_n, valid_d, kill;
  logic [N-1:0][VPN_W-1:0]  vpn_q, vpn_n;
  logic [N-1:0][ASID_W-1:0] asid_q, asid_n;
  logic [N-1:0][PPN_W-1:0]  ppn_q, ppn_n;

  logic [N-1:0]   lk_match, fl_match;
  logic [IW-1:0]  hit_idx, dup_idx, free_idx, lru_idx, fill_idx;
  logic           any_hit, any_dup, any_free;
  logic [PPN_W-1:0] hit_ppn;
  logic [VPN_W-1:0] lk_vpn;

  assign lk_vpn = lk_vaddr_i[VA_W-1:OFF_W];

  tlb_cam #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) i_cam_lk (
    .valid_i(valid_q), .vpn_i(vpn_q), .asid_i(asid_q),
    .key_vpn_i(lk_vpn), .key_asid_i(lk_asid_i), .match_o(lk_match)
  );

  tlb_cam #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) i_cam_fl (
    .valid_i(valid_q), .vpn_i(vpn_q), .asid_i(asid_q),
    .key_vpn_i(fill_vpn_i), .key_asid_i(fill_asid_i), .match_o(fl_match)
  );

  // lookup result, at most one match since fills never duplicate a tag
  always_comb begin
    hit_ppn = '0;
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (lk_match[i]) begin
        hit_ppn = hit_ppn | ppn_q[i];
        hit_idx = hit_idx | IW'(i);
      end
    end
  end

  assign any_hit    = |lk_match;
  assign lk_hit_o   = lk_valid_i && any_hit;
  assign lk_miss_o  = lk_valid_i && !any_hit;
  assign lk_paddr_o = lk_hit_o ? {hit_ppn, lk_vaddr_i[OFF_W-1:0]} : '0;

  // fill slot: existing tag, else lowest free, else LRU
  always_comb begin
    dup_idx  = '0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (fl_match[i]) dup_idx  = IW'(i);
      if (!valid_q[i]) free_idx = IW'(i);
    end
  end

  assign any_dup  = |fl_match;
  assign any_free = ~&valid_q;
  assign fill_idx = any_dup ? dup_idx : (any_free ? free_idx : lru_idx);

  tlb_lru #(.N(N)) i_lru (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .touch_i    (fill_valid_i || lk_hit_o),
    .touch_idx_i(fill_valid_i ? fill_idx : hit_idx),
    .lru_idx_o  (lru_idx)
  );

  always_comb begin
    valid_n = valid_q;
    vpn_n   = vpn_q;
    asid_n  = asid_q;
    ppn_n   = ppn_q;
    if (fill_valid_i) begin
      valid_n[fill_idx] = 1'b1;
      vpn_n[fill_idx]   = fill_vpn_i;
      asid_n[fill_idx]  = fill_asid_i;
      ppn_n[fill_idx]   = fill_ppn_i;
    end
  end

  // kill evaluated on post-fill contents so a same-cycle fill is covered
  tlb_kill #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) i_kill (
    .op_i      (inv_op_e'(inv_op_i)),
    .asid_i    (inv_asid_i),
    .lo_i      (inv_vpn_lo_i),
    .hi_i      (inv_vpn_hi_i),
    .ent_vpn_i (vpn_n),
    .ent_asid_i(asid_n),
    .kill_o    (kill)
  );

  assign valid_d = valid_n & ~kill;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else         valid_q <= valid_d;
  end

  always_ff @(posedge clk_i) begin
    vpn_q  <= vpn_n;
    asid_q <= asid_n;
    ppn_q  <= ppn_n;
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int OFF_W  = 12
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    lk_valid_i,
  input logic [ASID_W-1:0]       lk_asid_i,
  input logic [VPN_W+OFF_W-1:0]  lk_vaddr_i,
  input logic                    lk_hit_o,
  input logic                    lk_miss_o,
  input logic [PPN_W+OFF_W-1:0]  lk_paddr_o,
  input logic                    fill_valid_i,
  input logic [ASID_W-1:0]       fill_asid_i,
  input logic [VPN_W-1:0]        fill_vpn_i,
  input logic [PPN_W-1:0]        fill_ppn_i,
  input logic [1:0]              inv_op_i,
  input logic [ASID_W-1:0]       inv_asid_i,
  input logic [VPN_W-1:0]        inv_vpn_lo_i,
  input logic [VPN_W-1:0]        inv_vpn_hi_i
);
  logic [VPN_W-1:0] lk_vpn;
  assign lk_vpn = lk_vaddr_i[VPN_W+OFF_W-1:OFF_W];

  p_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lk_hit_o && lk_miss_o));

  p_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |-> (!lk_hit_o && !lk_miss_o));

  p_offset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (lk_paddr_o[OFF_W-1:0] == lk_vaddr_i[OFF_W-1:0]));

  p_flush_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_op_i == 2'd1) |=> !lk_hit_o);

  p_asid_gone_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_hit_o && $past(inv_op_i) == 2'd2) |-> (lk_asid_i != $past(inv_asid_i)));

  p_range_gone_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_hit_o && $past(inv_op_i) == 2'd3) |->
      (lk_vpn < $past(inv_vpn_lo_i) || lk_vpn > $past(inv_vpn_hi_i)));

  p_fill_visible_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(fill_valid_i) && $past(inv_op_i) == 2'd0 && lk_valid_i &&
     lk_asid_i == $past(fill_asid_i) && lk_vpn == $past(fill_vpn_i)) |->
      (lk_hit_o && lk_paddr_o[PPN_W+OFF_W-1:OFF_W] == $past(fill_ppn_i)));
endmodule

bind asid_tlb asid_tlb_chk #(
  .VPN_W(VPN_W), .PPN_W(PPN_W), .ASID_W(ASID_W), .OFF_W(OFF_W)
) i_asid_tlb_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .lk_valid_i(lk_valid_i), .lk_asid_i(lk_asid_i), .lk_vaddr_i(lk_vaddr_i),
  .lk_hit_o(lk_hit_o), .lk_miss_o(lk_miss_o), .lk_paddr_o(lk_paddr_o),
  .fill_valid_i(fill_valid_i), .fill_asid_i(fill_asid_i),
  .fill_vpn_i(fill_vpn_i), .fill_ppn_i(fill_ppn_i),
  .inv_op_i(inv_op_i), .inv_asid_i(inv_asid_i),
  .inv_vpn_lo_i(inv_vpn_lo_i), .inv_vpn_hi_i(inv_vpn_hi_i)
);

// File: tb/test_asid_tlb.sv
module test_asid_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [7:0]  lk_asid = '0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_hit, lk_miss;
  logic [31:0] lk_paddr;
  logic        fill_valid = 1'b0;
  logic [7:0]  fill_asid = '0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_ppn = '0;
  logic [1:0]  inv_op = '0;
  logic [7:0]  inv_asid = '0;
  logic [19:0] inv_lo = '0;
  logic [19:0] inv_hi = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  asid_tlb i_asid_tlb (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_asid_i(lk_asid), .lk_vaddr_i(lk_vaddr),
    .lk_hit_o(lk_hit), .lk_miss_o(lk_miss), .lk_paddr_o(lk_paddr),
    .fill_valid_i(fill_valid), .fill_asid_i(fill_asid),
    .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn),
    .inv_op_i(inv_op), .inv_asid_i(inv_asid),
    .inv_vpn_lo_i(inv_lo), .inv_vpn_hi_i(inv_hi)
  );

  task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got {hit,miss,paddr}=%h expected %h", req, act, exp);
    end
  endtask

  // probe; touch keeps the lookup up across the edge to refresh recency
  task automatic probe(input string req, input logic [7:0] asid, input logic [19:0] vpn,
                       input logic [11:0] off, input logic exp_hit,
                       input logic [19:0] exp_ppn, input logic touch = 1'b0);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_asid  = asid;
    lk_vaddr = {vpn, off};
    #2;
    check(req, {lk_hit, lk_miss, lk_paddr},
          exp_hit ? {2'b10, exp_ppn, off} : {2'b01, 32'h0});
    if (!touch) lk_valid = 1'b0;
    else begin
      @(posedge clk);
      #1 lk_valid = 1'b0;
    end
  endtask

  task automatic fill_inv(input logic do_fill, input logic [7:0] asid, input logic [19:0] vpn,
                          input logic [19:0] ppn, input logic [1:0] op,
                          input logic [7:0] ia, input logic [19:0] lo, input logic [19:0] hi);
    @(negedge clk);
    fill_valid = do_fill;
    fill_asid  = asid;
    fill_vpn   = vpn;
    fill_ppn   = ppn;
    inv_op     = op;
    inv_asid   = ia;
    inv_lo     = lo;
    inv_hi     = hi;
    @(negedge clk);
    fill_valid = 1'b0;
    inv_op     = 2'd0;
  endtask

  task automatic fill(input logic [7:0] asid, input logic [19:0] vpn, input logic [19:0] ppn);
    fill_inv(1'b1, asid, vpn, ppn, 2'd0, 8'h0, 20'h0, 20'h0);
  endtask

  task automatic flush();
    fill_inv(1'b0, 8'h0, 20'h0, 20'h0, 2'd1, 8'h0, 20'h0, 20'h0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    #2 check("R3 idle", {lk_hit, lk_miss, lk_paddr}, {2'b00, 32'h0});
    probe("R11 empty after reset", 8'h1, 20'h00000, 12'h000, 1'b0, 20'h0);
    probe("R11 empty after reset", 8'hFF, 20'hFFFFF, 12'hABC, 1'b0, 20'h0);
  endtask

  task automatic t_basic();
    fill(8'h01, 20'h12345, 20'hABCDE);
    probe("R2 paddr", 8'h01, 20'h12345, 12'h678, 1'b1, 20'hABCDE);
    probe("R1 offset ignored", 8'h01, 20'h12345, 12'hFFF, 1'b1, 20'hABCDE);
    probe("R1 asid mismatch", 8'h02, 20'h12345, 12'h678, 1'b0, 20'h0);
    probe("R3 vpn mismatch", 8'h01, 20'h12346, 12'h678, 1'b0, 20'h0);
    flush();
    probe("R7 flushed", 8'h01, 20'h12345, 12'h000, 1'b0, 20'h0);
  endtask

  task automatic t_capacity();
    for (int i = 0; i < 16; i++) fill(8'h01, 20'(i), 20'(32'h100 + i));
    for (int i = 0; i < 16; i++)
      probe("R4 all slots held", 8'h01, 20'(i), 12'h010, 1'b1, 20'(32'h100 + i));
  endtask

  task automatic t_lru();
    probe("R5 refresh vpn0", 8'h01, 20'h0, 12'h0, 1'b1, 20'h100, 1'b1);
    fill(8'h01, 20'd100, 20'h777);
    probe("R5 lru evicted", 8'h01, 20'h1, 12'h0, 1'b0, 20'h0);
    probe("R5 refreshed kept", 8'h01, 20'h0, 12'h0, 1'b1, 20'h100);
    probe("R5 new entry", 8'h01, 20'd100, 12'h0, 1'b1, 20'h777);
    probe("R5 other kept", 8'h01, 20'h2, 12'h0, 1'b1, 20'h102);
    flush();
  endtask

  task automatic t_overwrite();
    fill(8'h02, 20'h5, 20'h00001);
    fill(8'h02, 20'h5, 20'h00002);
    for (int i = 0; i < 15; i++) fill(8'h02, 20'(32'd20 + i), 20'(32'h200 + i));
    probe("R6 overwritten in place", 8'h02, 20'h5, 12'h0, 1'b1, 20'h00002);
    for (int i = 0; i < 15; i++)
      probe("R6 no duplicate slot used", 8'h02, 20'(32'd20 + i), 12'h0, 1'b1, 20'(32'h200 + i));
    flush();
  endtask

  task automatic t_asid_inv();
    fill(8'h03, 20'h1, 20'h31);
    fill(8'h04, 20'h1, 20'h41);
    fill(8'h03, 20'h2, 20'h32);
    fill_inv(1'b0, 8'h0, 20'h0, 20'h0, 2'd2, 8'h03, 20'h0, 20'h0);
    probe("R8 other asid kept", 8'h04, 20'h1, 12'h0, 1'b1, 20'h41);
    probe("R8 asid cleared", 8'h03, 20'h1, 12'h0, 1'b0, 20'h0);
    probe("R8 asid cleared", 8'h03, 20'h2, 12'h0, 1'b0, 20'h0);
    flush();
  endtask

  task automatic t_range();
    fill(8'h05, 20'h10, 20'h110);
    fill(8'h06, 20'h20, 20'h120);
    fill(8'h05, 20'h30, 20'h130);
    fill(8'h06, 20'h40, 20'h140);
    fill_inv(1'b0, 8'h0, 20'h0, 20'h0, 2'd3, 8'h0, 20'h20, 20'h30);
    probe("R9 below range kept", 8'h05, 20'h10, 12'h0, 1'b1, 20'h110);
    probe("R9 low bound cleared", 8'h06, 20'h20, 12'h0, 1'b0, 20'h0);
    probe("R9 high bound cleared", 8'h05, 20'h30, 12'h0, 1'b0, 20'h0);
    probe("R9 above range kept", 8'h06, 20'h40, 12'h0, 1'b1, 20'h140);
    flush();
  endtask

  task automatic t_same_cycle();
    fill(8'h07, 20'h70, 20'h170);
    fill_inv(1'b1, 8'h07, 20'h55, 20'h155, 2'd2, 8'h07, 20'h0, 20'h0);
    probe("R10 covered fill dropped", 8'h07, 20'h55, 12'h0, 1'b0, 20'h0);
    probe("R10 old entry cleared", 8'h07, 20'h70, 12'h0, 1'b0, 20'h0);
    fill_inv(1'b1, 8'h08, 20'h66, 20'h166, 2'd3, 8'h0, 20'h0, 20'h10);
    probe("R10 uncovered fill kept", 8'h08, 20'h66, 12'h0, 1'b1, 20'h166);
    fill_inv(1'b1, 8'h08, 20'h67, 20'h167, 2'd1, 8'h0, 20'h0, 20'h0);
    probe("R10 flush beats fill", 8'h08, 20'h67, 12'h0, 1'b0, 20'h0);
  endtask

  logic done = 1'b0;

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_capacity();
    t_lru();
    t_overwrite();
    t_asid_inv();
    t_range();
    t_same_cycle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule